// File: doc/BRIEF.md
# Vectorised Compare-and-Branch Predicate Unit

This block runs one comparison across a short vector of signed integer elements on behalf of a vectorised branch. Each lane compares an element of source A with the same element of source B. The lane results are packed into a predicate word that can be written to a predicate target. A single branch-taken flag is raised only when every participating lane succeeds.

Only four comparators are built: equal, not-equal, less-than and less-or-equal. Greater-than and greater-or-equal come from a swap bit that exchanges the two sources before they reach the comparators. A lane takes part only if its enable-mask bit is set and its index is below the element count. A single-cycle start pulse loads the registered outputs. The outputs are valid on the following cycle and hold their values until the next start.

Top module: `vbr_pred_unit`

## Requirements
- R1: Compare code 3'b000 (bit 2 swap, bit 1 family, bit 0 select) sets a lane's result when its A and B elements are equal.
- R2: Compare code 3'b001 sets a lane's result when its A and B elements differ.
- R3: Compare code 3'b010 sets a lane's result when A is less than B, with both elements treated as signed two's-complement values (0x80000000 < 0x7FFFFFFF).
- R4: Compare code 3'b011 sets a lane's result when A is less than or equal to B, signed.
- R5: Bit 2 of the compare code swaps the sources, so 3'b110 gives A greater than B and 3'b111 gives A greater than or equal to B. With the equality codes (3'b100) the swap does not change the result.
- R6: A lane whose mask bit is clear, or whose index is not below the element count, gives a 0 result bit and has no effect on the taken decision.
- R7: The taken flag is 1 only when at least one lane is active and every active lane's compare succeeds.
- R8: When the element count is 0 or no lane is active, the result word is all zeros and taken is 0.
- R9: The result of element i appears at bit i of the result word.
- R10: The result, taken and valid outputs are registered. Valid pulses for one cycle, one cycle after start. The outputs hold their values while start is low, and reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle request that captures a new compare |
| cmp_op | input | 3 | Compare code: {swap, family, select} |
| elem_cnt | input | $clog2(NUM_ELEM+1) | Number of leading elements that take part |
| en_mask | input | NUM_ELEM | Per-element enable |
| src_a | input | NUM_ELEM*ELEM_W | Packed A elements, element i at bits [i*ELEM_W +: ELEM_W] |
| src_b | input | NUM_ELEM*ELEM_W | Packed B elements, same layout as src_a |
| pred_out | output | NUM_ELEM | Predicate word, bit i for element i |
| taken | output | 1 | Branch-taken decision |
| valid | output | 1 | Pulses high when new outputs are presented |

## Verification
The assertions assume that start is a single-cycle pulse and that elem_cnt never exceeds NUM_ELEM. They also assume that cmp_op, elem_cnt, en_mask and both sources are stable in the cycle that start is high, because the checks relate the captured outputs to the inputs seen one cycle earlier. The bench drives every input on the falling edge, raises start for exactly one cycle, and keeps every element count in the range 0 to NUM_ELEM. It then changes the inputs with start low, which shows that the captured word is held.

// File: rtl/vbr_pkg.sv
package vbr_pkg;
   typedef enum logic [1:0] {
      PRIM_EQ = 2'b00,
      PRIM_NE = 2'b01,
      PRIM_LT = 2'b10,
      PRIM_LE = 2'b11
   } prim_e;

   localparam int OP_W = 3;
endpackage

// File: rtl/vbr_elem_cmp.sv
module vbr_elem_cmp
   import vbr_pkg::*;
#(
   parameter int ELEM_W     = 32,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic [ELEM_W-1:0] lhs,
   input  logic [ELEM_W-1:0] rhs,
   input  prim_e             prim,
   output logic              hit
);
   logic is_eq;
   logic is_lt;

   assign is_eq = (lhs == rhs);

   generate
      if (SIGNED_CMP) begin : g_signed
         assign is_lt = ($signed(lhs) < $signed(rhs));
      end else begin : g_unsigned
         assign is_lt = (lhs < rhs);
      end
   endgenerate

   always_comb begin
      unique case (prim)
         PRIM_EQ: hit = is_eq;
         PRIM_NE: hit = !is_eq;
         PRIM_LT: hit = is_lt;
         PRIM_LE: hit = is_lt || is_eq;
         default: hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/vbr_lane_gate.sv
module vbr_lane_gate #(
   parameter int NUM_ELEM = 8,
   localparam int CNT_W   = $clog2(NUM_ELEM + 1)
) (
   input  logic [CNT_W-1:0]    elem_cnt,
   input  logic [NUM_ELEM-1:0] en_mask,
   output logic [NUM_ELEM-1:0] active
);
   generate
      for (genvar i = 0; i < NUM_ELEM; i++) begin : g_lane
         localparam logic [CNT_W-1:0] IDX = CNT_W'(i);
         assign active[i] = en_mask[i] && (IDX < elem_cnt);
      end
   endgenerate
endmodule

// File: rtl/vbr_taken_reduce.sv
module vbr_taken_reduce #(
   parameter int NUM_ELEM = 8
) (
   input  logic [NUM_ELEM-1:0] active,
   input  logic [NUM_ELEM-1:0] hits,
   output logic [NUM_ELEM-1:0] res,
   output logic                all_ok
);
   logic [NUM_ELEM-1:0] pass_or_idle;

   assign res          = active & hits;
   assign pass_or_idle = hits | ~active;
   assign all_ok       = (|active) && (&pass_or_idle);
endmodule

// File: rtl/vbr_pred_unit.sv
module vbr_pred_unit
   import vbr_pkg::*;
#(
   parameter int  NUM_ELEM   = 8,
   parameter int  ELEM_W     = 32,
   parameter bit  SIGNED_CMP = 1'b1,
   localparam int CNT_W      = $clog2(NUM_ELEM + 1),
   localparam int VEC_W      = NUM_ELEM * ELEM_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [2:0]          cmp_op,
   input  logic [CNT_W-1:0]    elem_cnt,
   input  logic [NUM_ELEM-1:0] en_mask,
   input  logic [VEC_W-1:0]    src_a,
   input  logic [VEC_W-1:0]    src_b,
   output logic [NUM_ELEM-1:0] pred_out,
   output logic                taken,
   output logic                valid
);
   generate
      if (NUM_ELEM < 1 || NUM_ELEM > 64) begin : g_bad_num
         $error("vbr_pred_unit: NUM_ELEM must lie in 1..64");
      end
      if (ELEM_W < 2) begin : g_bad_width
         $error("vbr_pred_unit: ELEM_W must be at least 2");
      end
   endgenerate

   logic                swap;
   prim_e               prim;
   logic [NUM_ELEM-1:0] hits;
   logic [NUM_ELEM-1:0] active;
   logic [NUM_ELEM-1:0] res_d;
   logic                taken_d;

   assign swap = cmp_op[2];
   assign prim = prim_e'(cmp_op[1:0]);

   generate
      for (genvar i = 0; i < NUM_ELEM; i++) begin : g_elem
         logic [ELEM_W-1:0] a_el;
         logic [ELEM_W-1:0] b_el;
         assign a_el = src_a[i*ELEM_W +: ELEM_W];
         assign b_el = src_b[i*ELEM_W +: ELEM_W];

         vbr_elem_cmp #(
            .ELEM_W     (ELEM_W),
            .SIGNED_CMP (SIGNED_CMP)
         ) u_cmp (
            .lhs  (swap ? b_el : a_el),
            .rhs  (swap ? a_el : b_el),
            .prim (prim),
            .hit  (hits[i])
         );
      end
   endgenerate

   vbr_lane_gate #(.NUM_ELEM(NUM_ELEM)) u_gate (
      .elem_cnt (elem_cnt),
      .en_mask  (en_mask),
      .active   (active)
   );

   vbr_taken_reduce #(.NUM_ELEM(NUM_ELEM)) u_reduce (
      .active (active),
      .hits   (hits),
      .res    (res_d),
      .all_ok (taken_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pred_out <= '0;
         taken    <= 1'b0;
         valid    <= 1'b0;
      end else begin
         valid <= start;
         if (start) begin
            pred_out <= res_d;
            taken    <= taken_d;
         end
      end
   end

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> valid) else $error("valid missing after start"); // R10

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(start) |-> ($stable(pred_out) && $stable(taken))) else $error("outputs moved without start"); // R10

   AST_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> ((pred_out & ~$past(en_mask)) == '0)) else $error("disabled lane set"); // R6

   AST_TAKEN_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && taken) |-> (pred_out == $past(active) && pred_out != '0)) else $error("taken with failing lane"); // R7

   AST_EMPTY_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && $past(elem_cnt) == '0) |-> (!taken && pred_out == '0)) else $error("empty vector gave result"); // R8
endmodule

// File: tb/vbr_pred_unit_bench.sv
module vbr_pred_unit_bench;
   localparam int N  = 8;
   localparam int W  = 32;
   localparam int CW = $clog2(N + 1);

   typedef struct packed {
      logic [2:0]    op;
      logic [CW-1:0] cnt;
      logic [N-1:0]  mask;
      logic [N-1:0]  res;
      logic          tk;
   } vec_t;

   // A = {5,-3,7,0,10,-8,2,2}, B = {5,4,7,-1,3,-8,9,2}
   // EQ A5, NE 5A, LT 42, LE E7, GT 18, GE BD
   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{3'b000, 4'd8, 8'hFF, 8'hA5, 1'b0},  // R1 R9
      '{3'b000, 4'd8, 8'hA5, 8'hA5, 1'b1},  // R1 R6 R7
      '{3'b001, 4'd8, 8'hFF, 8'h5A, 1'b0},  // R2
      '{3'b010, 4'd8, 8'hFF, 8'h42, 1'b0},  // R3
      '{3'b010, 4'd8, 8'h42, 8'h42, 1'b1},  // R3 R7
      '{3'b011, 4'd8, 8'hFF, 8'hE7, 1'b0},  // R4
      '{3'b011, 4'd3, 8'hFF, 8'h07, 1'b1},  // R4 R6 count
      '{3'b110, 4'd8, 8'hFF, 8'h18, 1'b0},  // R5 GT
      '{3'b110, 4'd8, 8'h18, 8'h18, 1'b1},  // R5 R7
      '{3'b111, 4'd8, 8'hFF, 8'hBD, 1'b0},  // R5 GE
      '{3'b111, 4'd8, 8'hBD, 8'hBD, 1'b1},  // R5 R7
      '{3'b100, 4'd8, 8'hFF, 8'hA5, 1'b0},  // R5 swap on EQ
      '{3'b000, 4'd0, 8'hFF, 8'h00, 1'b0},  // R8 count 0
      '{3'b001, 4'd8, 8'h00, 8'h00, 1'b0},  // R8 no mask
      '{3'b010, 4'd2, 8'hFF, 8'h02, 1'b0}   // R7 one failing lane
   };

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [2:0]     cmp_op = '0;
   logic [CW-1:0]  elem_cnt = '0;
   logic [N-1:0]   en_mask = '0;
   logic [N*W-1:0] src_a = '0;
   logic [N*W-1:0] src_b = '0;
   logic [N-1:0]   pred_out;
   logic           taken;
   logic           valid;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   vbr_pred_unit u_vbr_pred_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .cmp_op(cmp_op),
      .elem_cnt(elem_cnt), .en_mask(en_mask), .src_a(src_a), .src_b(src_b),
      .pred_out(pred_out), .taken(taken), .valid(valid)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic fire(input logic [2:0] op, input logic [CW-1:0] cnt, input logic [N-1:0] m);
      @(negedge clk);
      cmp_op = op; elem_cnt = cnt; en_mask = m; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   initial begin : watchdog
      #400000;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      int av [N] = '{5, -3, 7, 0, 10, -8, 2, 2};
      int bv [N] = '{5, 4, 7, -1, 3, -8, 9, 2};
      for (int i = 0; i < N; i++) begin
         src_a[i*W +: W] = av[i];
         src_b[i*W +: W] = bv[i];
      end
      repeat (3) @(negedge clk);
      check("R10 reset pred", 32'(pred_out), 0);
      check("R10 reset taken", 32'(taken), 0);
      check("R10 reset valid", 32'(valid), 0);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         fire(VECS[v].op, VECS[v].cnt, VECS[v].mask);
         check($sformatf("R10 valid vec%0d", v), 32'(valid), 1);
         check($sformatf("R1-9 pred vec%0d", v), 32'(pred_out), 32'(VECS[v].res));
         check($sformatf("R7 taken vec%0d", v), 32'(taken), 32'(VECS[v].tk));
      end

      // R10: hold with start low while inputs change
      fire(3'b000, 4'd8, 8'hA5);
      @(negedge clk);
      cmp_op = 3'b001; en_mask = 8'hFF;
      @(negedge clk);
      check("R10 valid drops", 32'(valid), 0);
      check("R10 pred held", 32'(pred_out), 32'h A5);
      check("R10 taken held", 32'(taken), 1);

      // R3: signed boundary in lane 0
      src_a[W-1:0] = 32'h8000_0000;
      src_b[W-1:0] = 32'h7FFF_FFFF;
      fire(3'b010, 4'd1, 8'h01);
      check("R3 signed pred", 32'(pred_out), 1);
      check("R3 signed taken", 32'(taken), 1);
      // R5: GT on the same pair is false
      fire(3'b110, 4'd1, 8'h01);
      check("R5 swapped pred", 32'(pred_out), 0);
      check("R5 swapped taken", 32'(taken), 0);
      // R9: only the top lane active
      src_a[(N-1)*W +: W] = 32'd9;
      src_b[(N-1)*W +: W] = 32'd9;
      fire(3'b000, 4'd8, 8'h80);
      check("R9 top lane", 32'(pred_out), 32'h80);
      check("R1 top lane taken", 32'(taken), 1);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule